// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment-Based Upper Groups

This block adds two 16-bit operands and a carry-in. It produces a 16-bit sum and a carry-out with no clock and no storage. The operand bits are split into groups whose widths grow from the least significant end. The lowest group is an ordinary ripple adder fed by the external carry-in.

Each higher group computes its sum once, with a ripple adder that assumes no carry enters. The result for an incoming carry is then formed by incrementing that sum together with its carry bit, rather than by a second adder. A 2:1 select, steered by the carry leaving the group below, picks one of the two results. The incrementer builds each toggle as a select between a bit and its inverse, controlled by the running AND of the lower bits.

The carries leaving every group boundary below the top are brought out so that neighbouring logic, or a test, can observe them.

Top module: `csla_sqrt_adder`

## Requirements
- R1: For every input, `{cout, sum}` equals the 17-bit value of `a + b + cin`.
- R2: The group widths, counted from bit 0 upward, are 2, 2, 3, 4 and 5 bits. The lowest group takes `cin` directly, and sum bits 1:0 depend only on `a[1:0]`, `b[1:0]` and `cin`.
- R3: In each upper group, the carry-in-one result equals the carry-in-zero result, with its carry bit, plus one. With `a` all ones, `b` zero and `cin` 1, the sum is zero and `cout` is 1.
- R4: The incrementer inverts bit 0, and inverts any higher bit exactly when all bits below it are 1. An operand whose low k bits are ones, added with `cin` 1 and `b` zero, yields `1 << k`.
- R5: Each upper group presents its carry-in-zero result when the carry from the group below is 0, and its incremented result when that carry is 1.
- R6: `grp_carry[0]`, `grp_carry[1]`, `grp_carry[2]` and `grp_carry[3]` are the carries out of bit positions 1, 3, 6 and 10. Each equals bit k+1 of `a[k:0] + b[k:0] + cin` for its position k.
- R7: With `a` = 1111010100011111, `b` = 1111011101110111 and `cin` 0, `sum` is 1110110010010110 and `cout` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |
| grp_carry | output | 4 | Carries out of bits 1, 3, 6 and 10 |

## Verification
The bench aims at carries that must cross every group boundary in one chain, such as all ones plus a carry-in. A faulty incrementer or select leaves a stray one or zero in the middle of the sum for that input. Walking single bits and operands with low runs of ones probe each incrementer toggle. An AND chain that misses a term would flip a bit too early or too late. Equal bits placed at each group's top position make that group's carry output rise alone. A boundary placed at the wrong bit shows up as a carry output at the wrong position, while the sum itself still looks plausible.

// File: rtl/csla_pkg.sv
package csla_pkg;
   // Nominal width of group k before trimming: 2, 2, 3, 4, 5, ...
   function automatic int grp_nom(int k);
      return (k < 2) ? 2 : k + 1;
   endfunction

   // Lowest bit position of group k
   function automatic int grp_lsb(int width, int k);
      int lsb;
      lsb = 0;
      for (int i = 0; i < 64; i++)
         if (i < k) lsb += grp_nom(i);
      return (lsb > width) ? width : lsb;
   endfunction

   // Width of group k, with the last group trimmed to fit
   function automatic int grp_w(int width, int k);
      int lsb;
      lsb = grp_lsb(width, k);
      return (grp_nom(k) > width - lsb) ? width - lsb : grp_nom(k);
   endfunction

   // Number of groups needed to cover the operand width
   function automatic int grp_cnt(int width);
      int n;
      n = 0;
      for (int i = 0; i < 64; i++)
         if (grp_lsb(width, i) < width) n++;
      return n;
   endfunction
endpackage

// File: rtl/csla_rca.sv
module csla_rca #(
   parameter int N = 2
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic         ci,
   output logic [N-1:0] s,
   output logic         co
);
   logic [N:0] c;
   assign c[0] = ci;

   for (genvar i = 0; i < N; i++) begin : g_fa
      assign s[i]   = a[i] ^ b[i] ^ c[i];
      assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
   end
   assign co = c[N];

   always_comb begin
      assert_rca_sum_R1: assert ({co, s} == {1'b0, a} + {1'b0, b} + {{N{1'b0}}, ci})
         else $error("ripple group sum mismatch");
   end
endmodule

// File: rtl/csla_bec.sv
module csla_bec #(
   parameter int N = 3
) (
   input  logic [N-1:0] x,
   output logic [N-1:0] y
);
   logic [N-1:0] run;

   assign run[0] = 1'b1;
   assign y[0]   = ~x[0];
   for (genvar i = 1; i < N; i++) begin : g_tog
      assign run[i] = run[i-1] & x[i-1];
      assign y[i]   = run[i] ? ~x[i] : x[i];
   end

   always_comb begin
      assert_bec_inc_R3: assert (y == x + {{(N-1){1'b0}}, 1'b1})
         else $error("incrementer result mismatch");
      assert_bec_lsb_R4: assert (y[0] != x[0])
         else $error("incrementer bit 0 not inverted");
   end
endmodule

// File: rtl/csla_group.sv
module csla_group #(
   parameter int GW    = 2,
   parameter bit FIRST = 1'b0
) (
   input  logic [GW-1:0] a,
   input  logic [GW-1:0] b,
   input  logic          ci,
   output logic [GW-1:0] s,
   output logic          co
);
   if (FIRST) begin : g_plain
      csla_rca #(.N(GW)) u_rca (.a(a), .b(b), .ci(ci), .s(s), .co(co));
   end else begin : g_select
      logic [GW-1:0] s0;
      logic          c0;
      logic [GW:0]   inc;

      csla_rca #(.N(GW)) u_rca (.a(a), .b(b), .ci(1'b0), .s(s0), .co(c0));
      csla_bec #(.N(GW + 1)) u_bec (.x({c0, s0}), .y(inc));

      assign {co, s} = ci ? inc : {c0, s0};

      always_comb begin
         assert_grp_select_R5: assert ({co, s} == {1'b0, a} + {1'b0, b} + {{GW{1'b0}}, ci})
            else $error("group select mismatch");
      end
   end
endmodule

// File: rtl/csla_sqrt_adder.sv
module csla_sqrt_adder
   import csla_pkg::*;
#(
   parameter  int WIDTH = 16,
   localparam int NGRP  = grp_cnt(WIDTH)
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic [NGRP-2:0]  grp_carry
);
   if (WIDTH < 4) begin : g_bad_width
      $error("WIDTH must be at least 4");
   end
   if (grp_lsb(WIDTH, NGRP - 1) + grp_w(WIDTH, NGRP - 1) != WIDTH) begin : g_bad_split
      $error("group split does not cover WIDTH");
   end

   logic [NGRP:0] cy;
   assign cy[0] = cin;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int LSB = grp_lsb(WIDTH, g);
      localparam int GW  = grp_w(WIDTH, g);
      localparam int HI  = LSB + GW - 1;

      csla_group #(.GW(GW), .FIRST(g == 0)) u_grp (
         .a (a[HI:LSB]),
         .b (b[HI:LSB]),
         .ci(cy[g]),
         .s (sum[HI:LSB]),
         .co(cy[g+1])
      );

      logic [HI+1:0] part;
      assign part = {1'b0, a[HI:0]} + {1'b0, b[HI:0]} + {{(HI+1){1'b0}}, cin};

      always_comb begin
         assert_grp_carry_R6: assert (cy[g+1] == part[HI+1])
            else $error("group carry mismatch");
      end
   end

   assign grp_carry = cy[NGRP-1:1];
   assign cout      = cy[NGRP];

   always_comb begin
      assert_total_R1: assert ({cout, sum} == {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin})
         else $error("total sum mismatch");
   end
endmodule

// File: tb/sim_csla_sqrt_adder.sv
module sim_csla_sqrt_adder;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic [W-1:0] a, b, sum;
   logic         cin, cout;
   logic [3:0]   grp_carry;

   int n_chk  = 0;
   int n_fail = 0;

   csla_sqrt_adder u0 (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .grp_carry(grp_carry));

   // Carry out of bit k for the low part of the operands
   function automatic logic carry_at(logic [W-1:0] x, logic [W-1:0] y, logic c, int k);
      logic [W:0] t;
      logic [W:0] m;
      m = ({{W{1'b0}}, 1'b1} << (k + 1)) - 1;
      t = ({1'b0, x} & m) + ({1'b0, y} & m) + {{W{1'b0}}, c};
      return t[k+1];
   endfunction

   task automatic apply_check(input logic [W-1:0] x, input logic [W-1:0] y,
                              input logic c, input string req);
      logic [W:0] exp;
      logic [3:0] exp_g;
      @(negedge clk);
      a = x; b = y; cin = c;
      #1;
      exp   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
      exp_g = {carry_at(x, y, c, 10), carry_at(x, y, c, 6),
               carry_at(x, y, c, 3), carry_at(x, y, c, 1)};
      n_chk++;
      if ({cout, sum} !== exp) begin
         n_fail++;
         $display("FAIL %s sum: got %b_%b expected %b_%b", req, cout, sum, exp[W], exp[W-1:0]);
      end
      n_chk++;
      if (grp_carry !== exp_g) begin
         n_fail++;
         $display("FAIL R6 grp_carry (%s): got %b expected %b", req, grp_carry, exp_g);
      end
   endtask

   task automatic t_zero();          // R1: all zeros
      apply_check('0, '0, 1'b0, "R1");
   endtask

   task automatic t_given();         // R7
      apply_check(16'b1111010100011111, 16'b1111011101110111, 1'b0, "R7");
      n_chk++;
      if (sum !== 16'b1110110010010110 || cout !== 1'b1) begin
         n_fail++;
         $display("FAIL R7 literal: got %b_%b expected 1_1110110010010110", cout, sum);
      end
   endtask

   task automatic t_all_ones();      // R3: carry crosses every group
      apply_check('1, '0, 1'b1, "R3");
      apply_check('1, '1, 1'b1, "R3");
      apply_check('1, '1, 1'b0, "R3");
   endtask

   task automatic t_low_runs();      // R4: low run of ones plus carry-in
      for (int k = 1; k <= W; k++)
         apply_check(W'((32'd1 << k) - 1), '0, 1'b1, "R4");
   endtask

   task automatic t_walk();          // R2/R4: walking single bits
      for (int i = 0; i < W; i++) begin
         apply_check(W'(32'd1 << i), '0, 1'b0, "R2");
         apply_check(W'(32'd1 << i), '1, 1'b0, "R4");
         apply_check('0, W'(32'd1 << i), 1'b1, "R2");
      end
   endtask

   task automatic t_boundaries();    // R5/R6: carry generated at each group top
      int tops[4] = '{1, 3, 6, 10};
      foreach (tops[j]) begin
         apply_check(W'(32'd1 << tops[j]), W'(32'd1 << tops[j]), 1'b0, "R5");
         apply_check(W'((32'd1 << (tops[j] + 1)) - 1), '0, 1'b1, "R5");
      end
   endtask

   task automatic t_random();        // R1
      for (int n = 0; n < 10000; n++)
         apply_check(W'($urandom), W'($urandom), 1'($urandom), "R1");
   endtask

   initial begin
      a = '0; b = '0; cin = 1'b0;
      t_zero();
      t_given();
      t_all_ones();
      t_low_runs();
      t_walk();
      t_boundaries();
      t_random();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule